// File: doc/BRIEF.md
# Indexed chipset configuration port

This block is the configuration register file of a legacy PC chipset, reached by the host through two byte-wide I/O ports. One port selects a register index and the other transfers data to or from the selected byte. The block holds 256 configuration bytes. A handful of these bytes are decoded into control outputs: the two cache enables, the enable for the fast-reset/A20 port decode, and four PCI interrupt routing fields, each with a valid flag.

Writes to every register except the key register are dropped unless the key register holds a magic unlock value. One register has a bit that is forced to zero when written. Some CPU families reserve part of the index space for their own registers. When a strap input marks such a CPU, data-port reads of those indexes return all-ones. Memory decoding and the interrupt controller that consumes the routing fields are outside this block.

Top module: `cfg_index_port`

## Requirements
- R1: A byte-wide write to address 0x0022 loads the index register with the written byte, whatever the lock state.
- R2: A byte-wide write to address 0x0023 stores the byte at the current index, and a byte-wide read of 0x0023 returns the byte held at the current index on `io_rdata` in the same cycle.
- R3: Index 0x03 is the key register and is always writable. A data write to any other index is discarded unless the key register holds 0xC5. Writing any other value to the key register locks the file again and freezes all other registers.
- R4: A write to index 0x14 stores the byte ANDed with 0xBF, so bit 6 of that register always reads back 0.
- R5: `icache_en` follows bit 0 of index 0x16 and `ecache_en` follows bit 1 of index 0x16.
- R6: `fastrst_port_en` follows bit 4 of index 0x29.
- R7: `irq_route` carries four 4-bit fields: [3:0] is INTA (index 0x42 bits 3:0), [7:4] is INTB (0x42 bits 7:4), [11:8] is INTC (0x43 bits 3:0) and [15:12] is INTD (0x43 bits 7:4). Bit n of `irq_route_en` is 1 exactly when field n is nonzero; a zero field means the line is disabled.
- R8: While `cpu_rsv_strap` is 1, a data-port read returns 0xFF when the index is 0x20 or at least 0xC0. While the strap is 0, such a read returns the stored byte.
- R9: `io_rdata` is 0xFF for a read of any address other than 0x0023, including the index port, and whenever no read is in progress.
- R10: An access whose 16-bit address differs from both ports, or that has `io_byte_en` low, changes neither the index nor any register.
- R11: After reset the index is 0x00 and every register is 0x00, except index 0x3C = 0x03, 0x3D = 0x01 and 0x40 = 0x03. All decoded outputs are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host I/O write strobe, one cycle per transfer |
| io_rd | input | 1 | Host I/O read strobe |
| io_byte_en | input | 1 | Transfer is byte-wide |
| cpu_rsv_strap | input | 1 | CPU family reserves index 0x20 and 0xC0 upward |
| io_rdata | output | 8 | Read data, 0xFF when not a data-port read |
| icache_en | output | 1 | Internal cache enable |
| ecache_en | output | 1 | External cache enable |
| fastrst_port_en | output | 1 | Enables the fast-reset/A20 port decode |
| irq_route | output | 16 | Four 4-bit PCI interrupt route fields, INTA lowest |
| irq_route_en | output | 4 | Per-line route valid, nonzero field |

## Verification
The checker tests several rules on every cycle. Reads outside the data port return all-ones. Reads of the reserved range are blanked while the strap is set. An index-port write lands in the index. No decoded output moves while the file is locked, or on a cycle that carries only a partial-width or mismatched access. Only the bench's scenarios can show the stored contents: the reset table, the bit-6 mask on index 0x14, the mapping of each bit and nibble onto its output, and the fact that relocking keeps the programmed values. The bench reads these back through the data port or observes them on the outputs.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   localparam int REG_W    = 8;
   localparam int IDX_W    = 8;
   localparam int NUM_REGS = 1 << IDX_W;
   localparam int NUM_TAPS = 4;

   // Order of the register taps presented to the control decoder
   typedef enum int {
      TAP_CACHE    = 0,
      TAP_CLOCK    = 1,
      TAP_ROUTE_AB = 2,
      TAP_ROUTE_CD = 3
   } tap_e;

   localparam logic [IDX_W-1:0] TAP_IDX [NUM_TAPS] = '{8'h16, 8'h29, 8'h42, 8'h43};

   // Power-on contents: zero except a few fixed defaults
   function automatic logic [REG_W-1:0] reset_value(input logic [IDX_W-1:0] idx);
      case (idx)
         8'h3C:   return 8'h03;
         8'h3D:   return 8'h01;
         8'h40:   return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

   // Bits that a write may set; cleared bits always store zero
   function automatic logic [REG_W-1:0] write_mask(input logic [IDX_W-1:0] idx);
      case (idx)
         8'h14:   return 8'hBF;
         default: return 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] IDX_PORT  = 'h22,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h23
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic              io_byte_en,
   output logic              idx_wr,
   output logic              dat_wr,
   output logic              dat_rd
);
   logic hit_idx, hit_dat;

   assign hit_idx = io_byte_en && (io_addr == IDX_PORT);
   assign hit_dat = io_byte_en && (io_addr == DATA_PORT);

   assign idx_wr = io_wr && hit_idx;
   assign dat_wr = io_wr && hit_dat;
   assign dat_rd = io_rd && hit_dat;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfg_port_pkg::*;
#(
   parameter logic [IDX_W-1:0] KEY_IDX = 8'h03,
   parameter logic [REG_W-1:0] KEY_VAL = 8'hC5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            idx_wr,
   input  logic                            dat_wr,
   input  logic [REG_W-1:0]                wdata,
   output logic [IDX_W-1:0]                idx_q,
   output logic [REG_W-1:0]                rd_byte,
   output logic                            unlocked,
   output logic [NUM_TAPS-1:0][REG_W-1:0]  taps
);
   logic [REG_W-1:0] mem [NUM_REGS];
   logic             wr_ok;

   assign unlocked = (mem[KEY_IDX] == KEY_VAL);
   assign wr_ok    = dat_wr && ((idx_q == KEY_IDX) || unlocked);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < NUM_REGS; i++)
            mem[i] <= reset_value(IDX_W'(i));
      end else begin
         if (idx_wr)
            idx_q <= wdata;
         if (wr_ok)
            mem[idx_q] <= wdata & write_mask(idx_q);
      end
   end

   assign rd_byte = mem[idx_q];

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      assign taps[t] = mem[TAP_IDX[t]];
   end
endmodule

// File: rtl/cfg_ctl_decode.sv
module cfg_ctl_decode
   import cfg_port_pkg::*;
#(
   parameter int NUM_ROUTES = 4,
   parameter int ROUTE_W    = 4,
   parameter int ICACHE_BIT = 0,
   parameter int ECACHE_BIT = 1,
   parameter int FRST_BIT   = 4,
   localparam int ROUTE_BUS_W = NUM_ROUTES * ROUTE_W
) (
   input  logic [NUM_TAPS-1:0][REG_W-1:0] taps,
   output logic                           icache_en,
   output logic                           ecache_en,
   output logic                           fastrst_port_en,
   output logic [ROUTE_BUS_W-1:0]         irq_route,
   output logic [NUM_ROUTES-1:0]          irq_route_en
);
   logic [ROUTE_BUS_W-1:0] route_bus;
   logic [REG_W-1:0]       unused_cache_tap;
   logic [REG_W-1:0]       unused_clock_tap;

   assign icache_en       = taps[TAP_CACHE][ICACHE_BIT];
   assign ecache_en       = taps[TAP_CACHE][ECACHE_BIT];
   assign fastrst_port_en = taps[TAP_CLOCK][FRST_BIT];
   assign unused_cache_tap = taps[TAP_CACHE];
   assign unused_clock_tap = taps[TAP_CLOCK];

   assign route_bus = {taps[TAP_ROUTE_CD], taps[TAP_ROUTE_AB]};

   for (genvar r = 0; r < NUM_ROUTES; r++) begin : g_route
      logic [ROUTE_W-1:0] field;
      assign field                            = route_bus[r*ROUTE_W +: ROUTE_W];
      assign irq_route[r*ROUTE_W +: ROUTE_W]  = field;
      assign irq_route_en[r]                  = |field;
   end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_port_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] IDX_PORT   = 'h22,
   parameter logic [ADDR_W-1:0] DATA_PORT  = 'h23,
   parameter logic [IDX_W-1:0]  KEY_IDX    = 8'h03,
   parameter logic [REG_W-1:0]  KEY_VAL    = 8'hC5,
   parameter bit                RSV_BLANK  = 1'b1,
   parameter logic [IDX_W-1:0]  RSV_SINGLE = 8'h20,
   parameter logic [IDX_W-1:0]  RSV_FLOOR  = 8'hC0,
   parameter int                NUM_ROUTES = 4,
   parameter int                ROUTE_W    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             io_addr,
   input  logic [REG_W-1:0]              io_wdata,
   input  logic                          io_wr,
   input  logic                          io_rd,
   input  logic                          io_byte_en,
   input  logic                          cpu_rsv_strap,
   output logic [REG_W-1:0]              io_rdata,
   output logic                          icache_en,
   output logic                          ecache_en,
   output logic                          fastrst_port_en,
   output logic [NUM_ROUTES*ROUTE_W-1:0] irq_route,
   output logic [NUM_ROUTES-1:0]         irq_route_en
);
   localparam logic [REG_W-1:0] ALL_ONES = '1;

   if (IDX_PORT == DATA_PORT) begin : g_bad_ports
      $error("index and data ports must differ");
   end
   if (NUM_ROUTES * ROUTE_W != 2 * REG_W) begin : g_bad_routes
      $error("route fields must fill exactly two registers");
   end

   logic                           idx_wr, dat_wr, dat_rd;
   logic [IDX_W-1:0]               idx_q;
   logic [REG_W-1:0]               rd_byte;
   logic                           unlocked;
   logic [NUM_TAPS-1:0][REG_W-1:0] taps;
   logic                           rsv_hit;

   cfg_port_decode #(
      .ADDR_W   (ADDR_W),
      .IDX_PORT (IDX_PORT),
      .DATA_PORT(DATA_PORT)
   ) u_decode (
      .io_addr   (io_addr),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .io_byte_en(io_byte_en),
      .idx_wr    (idx_wr),
      .dat_wr    (dat_wr),
      .dat_rd    (dat_rd)
   );

   cfg_reg_bank #(
      .KEY_IDX(KEY_IDX),
      .KEY_VAL(KEY_VAL)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (idx_wr),
      .dat_wr  (dat_wr),
      .wdata   (io_wdata),
      .idx_q   (idx_q),
      .rd_byte (rd_byte),
      .unlocked(unlocked),
      .taps    (taps)
   );

   cfg_ctl_decode #(
      .NUM_ROUTES(NUM_ROUTES),
      .ROUTE_W   (ROUTE_W)
   ) u_ctl (
      .taps           (taps),
      .icache_en      (icache_en),
      .ecache_en      (ecache_en),
      .fastrst_port_en(fastrst_port_en),
      .irq_route      (irq_route),
      .irq_route_en   (irq_route_en)
   );

   if (RSV_BLANK) begin : g_rsv_blank
      assign rsv_hit = cpu_rsv_strap && ((idx_q == RSV_SINGLE) || (idx_q >= RSV_FLOOR));
   end else begin : g_rsv_none
      logic unused_strap;
      assign unused_strap = cpu_rsv_strap;
      assign rsv_hit      = 1'b0;
   end

   assign io_rdata = (dat_rd && !rsv_hit) ? rd_byte : ALL_ONES;
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] IDX_PORT   = 'h22,
   parameter logic [ADDR_W-1:0] DATA_PORT  = 'h23,
   parameter bit                RSV_BLANK  = 1'b1,
   parameter logic [7:0]        RSV_SINGLE = 8'h20,
   parameter logic [7:0]        RSV_FLOOR  = 8'hC0,
   parameter int                ROUTE_BUS  = 16,
   parameter int                NUM_ROUTES = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     io_addr,
   input logic [7:0]            io_wdata,
   input logic                  io_wr,
   input logic                  io_rd,
   input logic                  io_byte_en,
   input logic                  cpu_rsv_strap,
   input logic [7:0]            io_rdata,
   input logic                  icache_en,
   input logic                  ecache_en,
   input logic                  fastrst_port_en,
   input logic [ROUTE_BUS-1:0]  irq_route,
   input logic [NUM_ROUTES-1:0] irq_route_en,
   input logic [7:0]            idx_q,
   input logic                  unlocked
);
   logic [ROUTE_BUS+NUM_ROUTES+2:0] outs;
   assign outs = {icache_en, ecache_en, fastrst_port_en, irq_route, irq_route_en};

   // R1: index port write lands in the index on the next cycle
   p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_byte_en && io_addr == IDX_PORT) |=> (idx_q == $past(io_wdata)));

   // R3: nothing decoded moves while the file is locked
   p_locked_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(outs));

   // R8: reserved index range reads as all-ones under the strap
   p_rsv_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (RSV_BLANK && io_rd && io_byte_en && io_addr == DATA_PORT && cpu_rsv_strap &&
       (idx_q == RSV_SINGLE || idx_q >= RSV_FLOOR)) |-> (io_rdata == 8'hFF));

   // R9: only the data port returns data
   p_other_read_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_byte_en && io_addr == DATA_PORT) |-> (io_rdata == 8'hFF));

   // R10: partial-width or unmatched writes touch no state
   p_ignored_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && (!io_byte_en || (io_addr != IDX_PORT && io_addr != DATA_PORT)))
      |=> ($stable(idx_q) && $stable(outs)));
endmodule

bind cfg_index_port cfg_index_port_chk #(
   .ADDR_W    (ADDR_W),
   .IDX_PORT  (IDX_PORT),
   .DATA_PORT (DATA_PORT),
   .RSV_BLANK (RSV_BLANK),
   .RSV_SINGLE(RSV_SINGLE),
   .RSV_FLOOR (RSV_FLOOR),
   .ROUTE_BUS (NUM_ROUTES*ROUTE_W),
   .NUM_ROUTES(NUM_ROUTES)
) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .io_addr        (io_addr),
   .io_wdata       (io_wdata),
   .io_wr          (io_wr),
   .io_rd          (io_rd),
   .io_byte_en     (io_byte_en),
   .cpu_rsv_strap  (cpu_rsv_strap),
   .io_rdata       (io_rdata),
   .icache_en      (icache_en),
   .ecache_en      (ecache_en),
   .fastrst_port_en(fastrst_port_en),
   .irq_route      (irq_route),
   .irq_route_en   (irq_route_en),
   .idx_q          (idx_q),
   .unlocked       (unlocked)
);

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic        io_byte_en = 1'b1;
   logic        cpu_rsv_strap = 1'b0;
   logic [7:0]  io_rdata;
   logic        icache_en, ecache_en, fastrst_port_en;
   logic [15:0] irq_route;
   logic [3:0]  irq_route_en;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   cfg_index_port i_cfg_index_port (
      .clk            (clk),
      .rst_n          (rst_n),
      .io_addr        (io_addr),
      .io_wdata       (io_wdata),
      .io_wr          (io_wr),
      .io_rd          (io_rd),
      .io_byte_en     (io_byte_en),
      .cpu_rsv_strap  (cpu_rsv_strap),
      .io_rdata       (io_rdata),
      .icache_en      (icache_en),
      .ecache_en      (ecache_en),
      .fastrst_port_en(fastrst_port_en),
      .irq_route      (irq_route),
      .irq_route_en   (irq_route_en)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic be = 1'b1);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_byte_en = be; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_byte_en = 1'b1; io_addr = 16'h0000;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0; io_addr = 16'h0000;
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
      io_write(16'h0022, idx);
      io_write(16'h0023, d);
   endtask

   task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
      io_write(16'h0022, idx);
      io_read(16'h0023, d);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R11 icache_en", icache_en, 0);
      check("R11 fastrst", fastrst_port_en, 0);
      check("R11 route", {irq_route, irq_route_en}, 0);
      io_read(16'h0023, d);   check("R11 index 0 after reset", d, 8'h00);
      reg_read(8'h40, d);     check("R1 R11 idx40", d, 8'h03);
      reg_read(8'h3C, d);     check("R11 idx3C", d, 8'h03);
      reg_read(8'h3D, d);     check("R11 idx3D", d, 8'h01);
      reg_read(8'h16, d);     check("R11 idx16", d, 8'h00);
   endtask

   task automatic t_lock;
      logic [7:0] d;
      reg_write(8'h16, 8'h03);
      reg_read(8'h16, d);     check("R3 locked write dropped", d, 8'h00);
      check("R3 locked icache", icache_en, 0);
      reg_write(8'h03, 8'hC5);
      reg_read(8'h03, d);     check("R3 key readback", d, 8'hC5);
      reg_write(8'h16, 8'h03);
      reg_read(8'h16, d);     check("R2 R3 unlocked store", d, 8'h03);
      reg_write(8'h03, 8'h00);
      reg_write(8'h16, 8'h00);
      reg_read(8'h16, d);     check("R3 relocked frozen", d, 8'h03);
      check("R3 relocked icache", icache_en, 1);
      reg_write(8'h03, 8'hC5);
   endtask

   task automatic t_cache;
      reg_write(8'h16, 8'h01);
      check("R5 icache on", {icache_en, ecache_en}, 2'b10);
      reg_write(8'h16, 8'hFE);
      check("R5 ecache on", {icache_en, ecache_en}, 2'b01);
   endtask

   task automatic t_mask;
      logic [7:0] d;
      reg_write(8'h14, 8'hFF);
      reg_read(8'h14, d);     check("R4 bit6 masked", d, 8'hBF);
      reg_write(8'h14, 8'h40);
      reg_read(8'h14, d);     check("R4 bit6 alone", d, 8'h00);
   endtask

   task automatic t_fastrst;
      reg_write(8'h29, 8'h10);
      check("R6 fastrst on", fastrst_port_en, 1);
      reg_write(8'h29, 8'hEF);
      check("R6 fastrst off", fastrst_port_en, 0);
   endtask

   task automatic t_routes;
      reg_write(8'h42, 8'hB5);
      reg_write(8'h43, 8'h0A);
      check("R7 route fields", irq_route, 16'h0AB5);
      check("R7 route enables", irq_route_en, 4'b0111);
      reg_write(8'h42, 8'h00);
      check("R7 route disabled", irq_route_en, 4'b0100);
   endtask

   task automatic t_reserved;
      logic [7:0] d;
      reg_write(8'h20, 8'h5A);
      reg_write(8'hC0, 8'h66);
      reg_write(8'hFF, 8'h77);
      reg_write(8'hBF, 8'h11);
      cpu_rsv_strap = 1'b1;
      reg_read(8'h20, d);     check("R8 idx20 blanked", d, 8'hFF);
      reg_read(8'hC0, d);     check("R8 idxC0 blanked", d, 8'hFF);
      reg_read(8'hFF, d);     check("R8 idxFF blanked", d, 8'hFF);
      reg_read(8'hBF, d);     check("R8 idxBF visible", d, 8'h11);
      cpu_rsv_strap = 1'b0;
      reg_read(8'h20, d);     check("R8 idx20 no strap", d, 8'h5A);
      reg_read(8'hC0, d);     check("R8 idxC0 no strap", d, 8'h66);
   endtask

   task automatic t_other_ports;
      logic [7:0] d;
      io_write(16'h0022, 8'h40);
      io_read(16'h0022, d);   check("R9 index port read", d, 8'hFF);
      io_read(16'h0123, d);   check("R9 alias address read", d, 8'hFF);
      #1 check("R9 idle rdata", io_rdata, 8'hFF);
   endtask

   task automatic t_ignored;
      logic [7:0] d;
      reg_write(8'h40, 8'h03);
      io_write(16'h1022, 8'h16);
      io_read(16'h0023, d);   check("R10 unmatched index write", d, 8'h03);
      io_write(16'h0023, 8'h99, 1'b0);
      io_read(16'h0023, d);   check("R10 partial-width write", d, 8'h03);
      io_write(16'h0123, 8'h99);
      io_read(16'h0023, d);   check("R10 unmatched data write", d, 8'h03);
      io_write(16'h0022, 8'h16, 1'b0);
      io_read(16'h0023, d);   check("R10 partial-width index", d, 8'h03);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_lock;
      t_cache;
      t_mask;
      t_fastrst;
      t_routes;
      t_reserved;
      t_other_ports;
      t_ignored;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule